// File: doc/BRIEF.md
# Transfer Event Flag and Interrupt Unit

This block sits beside a multi-channel transfer engine. Each channel raises three kinds of one-cycle event pulses: half of a transfer done, the whole transfer done, and a transfer error. The block catches every pulse in a sticky flag. Software sees the flags through a read-only status word. It removes them by writing ones to a separate clear word, which reads back as zero.

A per-channel enable word gates the flags onto level interrupt lines. Two neighbouring channels, chosen by parameter, are merged onto one line. Every other channel owns a line of its own. Each channel also shows a summary bit that is set while any of its three flags is set. Writing the summary bit in the clear word removes all three flags of that channel.

Register access uses plain write and read strobes with a two-bit word address. Read data is registered.

Top module: `dma_irq_unit`

## Requirements
- R1: After reset, every flag and every enable bit is zero, all interrupt lines are low and `bus_rdata` is zero.
- R2: A one-cycle pulse on `evt_tc`, `evt_ht` or `evt_err` for channel c sets the matching sticky flag at the next clock edge. The flag stays set until it is cleared. Channel c owns status bits 4c+3..4c: bit 4c+1 is the whole-transfer flag, bit 4c+2 the half-transfer flag, and bit 4c+3 the error flag.
- R3: Status bit 4c, the summary bit, reads 1 exactly when at least one of the three flags of channel c is set.
- R4: The status word is at address 0. A write to it changes no flag.
- R5: A write to the clear word at address 1 with a 1 in bit 4c+1, 4c+2 or 4c+3 clears only that flag. Zero bits leave their flags unchanged.
- R6: A 1 written to bit 4c of the clear word clears all three flags of channel c.
- R7: A read of the clear word returns zero.
- R8: If an event pulse and a clear of the same flag fall in the same cycle, the flag is set afterwards. This holds whether the clear comes from its own bit or from the summary bit.
- R9: The enable word at address 2 uses the same field layout: bit 4c+1 enables the whole-transfer flag, 4c+2 the half-transfer flag and 4c+3 the error flag. Bit 4c is not stored and reads 0. Address 3 reads 0 and ignores writes.
- R10: An interrupt line is high while at least one enabled flag mapped to it is set, and low otherwise. A flag whose enable bit is 0 never raises a line.
- R11: Channels SHARE_LO and SHARE_LO+1 both drive line SHARE_LO. Channel c below SHARE_LO drives line c, and channel c above SHARE_LO+1 drives line c-1. With the defaults (7 channels, SHARE_LO=3) there are 6 lines.
- R12: `bus_rdata` takes the addressed word at the clock edge where `bus_rd` is high, and otherwise holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_ht | input | NCH | Half-transfer event pulses, one per channel |
| evt_tc | input | NCH | Whole-transfer event pulses, one per channel |
| evt_err | input | NCH | Error event pulses, one per channel |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 2 | Word address: 0 status, 1 clear, 2 enable |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Registered read data |
| irq_out | output | NCH-1 | Level interrupt lines |

## Verification
Two functions can act on the same flag in the same cycle: a hardware event pulse and a software write to the clear word. The bench drives both in the same cycle, once against the flag's own clear bit and once against the channel's summary bit. It then reads the status word and expects the pulsed flag to be set. In the summary-bit case it also expects the channel's other flags to be cleared.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;

    localparam int FLD_W   = 4;
    localparam int FLD_GLB = 0;
    localparam int FLD_TC  = 1;
    localparam int FLD_HT  = 2;
    localparam int FLD_ERR = 3;

    typedef enum logic [1:0] {
        REG_STATUS = 2'd0,
        REG_CLEAR  = 2'd1,
        REG_ENABLE = 2'd2,
        REG_NONE   = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/dma_irq_chan_flags.sv
module dma_irq_chan_flags
    import dma_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_tc,
    input  logic             set_ht,
    input  logic             set_err,
    input  logic [FLD_W-1:0] clr_field,
    input  logic [FLD_W-1:0] en_field,
    output logic [FLD_W-1:0] status_field,
    output logic             pending
);

    logic [2:0] flags_q;
    logic [2:0] set_vec;
    logic [2:0] clr_eff;
    logic [2:0] en_vec;

    always_comb begin
        set_vec = {set_err, set_ht, set_tc};
        clr_eff = clr_field[FLD_ERR:FLD_TC] | {3{clr_field[FLD_GLB]}};
        en_vec  = en_field[FLD_ERR:FLD_TC];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= set_vec | (flags_q & ~clr_eff);
    end

    always_comb begin
        status_field          = '0;
        status_field[FLD_TC]  = flags_q[0];
        status_field[FLD_HT]  = flags_q[1];
        status_field[FLD_ERR] = flags_q[2];
        status_field[FLD_GLB] = |flags_q;
        pending               = |(flags_q & en_vec);
    end

    AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_vec) |=> ((flags_q & $past(set_vec)) == $past(set_vec))); // R8
    AST_CLR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_eff & ~set_vec)) |=> ((flags_q & $past(clr_eff & ~set_vec)) == 3'b000)); // R5
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec == 3'b000) |=> ((flags_q & ~$past(flags_q)) == 3'b000)); // R2

endmodule

// File: rtl/dma_irq_route.sv
module dma_irq_route #(
    parameter int NCH      = 7,
    parameter int SHARE_LO = 3
) (
    input  logic [NCH-1:0] pend,
    output logic [NCH-2:0] irq
);

    for (genvar l = 0; l < NCH - 1; l++) begin : g_line
        if (l < SHARE_LO) begin : g_own
            assign irq[l] = pend[l];
        end else if (l == SHARE_LO) begin : g_shared
            assign irq[l] = pend[l] | pend[l+1];
        end else begin : g_shift
            assign irq[l] = pend[l+1];
        end
    end

endmodule

// File: rtl/dma_irq_unit.sv
module dma_irq_unit
    import dma_irq_pkg::*;
#(
    parameter int NCH      = 7,
    parameter int SHARE_LO = 3,
    parameter int DW       = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] evt_ht,
    input  logic [NCH-1:0] evt_tc,
    input  logic [NCH-1:0] evt_err,
    input  logic           bus_wr,
    input  logic           bus_rd,
    input  logic [1:0]     bus_addr,
    input  logic [DW-1:0]  bus_wdata,
    output logic [DW-1:0]  bus_rdata,
    output logic [NCH-2:0] irq_out
);

    localparam int FW = NCH * FLD_W;
    localparam logic [FW-1:0] EN_MASK = {NCH{4'b1110}};

    reg_sel_e        sel;
    logic [FW-1:0]   status_word;
    logic [FW-1:0]   enable_q;
    logic [FW-1:0]   clr_word;
    logic [NCH-1:0]  pend;
    logic [DW-1:0]   rd_next;

    assign sel      = reg_sel_e'(bus_addr);
    assign clr_word = (bus_wr && sel == REG_CLEAR) ? bus_wdata[FW-1:0] : '0;

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        dma_irq_chan_flags u_chan (
            .clk          (clk),
            .rst_n        (rst_n),
            .set_tc       (evt_tc[c]),
            .set_ht       (evt_ht[c]),
            .set_err      (evt_err[c]),
            .clr_field    (clr_word[c*FLD_W +: FLD_W]),
            .en_field     (enable_q[c*FLD_W +: FLD_W]),
            .status_field (status_word[c*FLD_W +: FLD_W]),
            .pending      (pend[c])
        );
    end

    dma_irq_route #(.NCH(NCH), .SHARE_LO(SHARE_LO)) u_route (
        .pend (pend),
        .irq  (irq_out)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)                          enable_q <= '0;
        else if (bus_wr && sel == REG_ENABLE) enable_q <= bus_wdata[FW-1:0] & EN_MASK;
    end

    always_comb begin
        rd_next = '0;
        unique case (sel)
            REG_STATUS: rd_next[FW-1:0] = status_word;
            REG_ENABLE: rd_next[FW-1:0] = enable_q;
            REG_CLEAR:  rd_next = '0;
            default:    rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_next;
    end

    AST_CLEAR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && sel == REG_CLEAR) |=> (bus_rdata == '0)); // R7
    AST_STATUS_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && sel == REG_STATUS && !(|evt_tc) && !(|evt_ht) && !(|evt_err))
        |=> (status_word == $past(status_word))); // R4
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_q == '0) |-> (irq_out == '0)); // R10
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata)); // R12

endmodule

// File: tb/test_dma_irq_unit.sv
`timescale 1ns/1ps
module test_dma_irq_unit;

    localparam int NCH = 7;
    localparam int DW  = 32;

    logic           clk = 1'b0;
    logic           rst_n;
    logic [NCH-1:0] evt_ht, evt_tc, evt_err;
    logic           bus_wr, bus_rd;
    logic [1:0]     bus_addr;
    logic [DW-1:0]  bus_wdata;
    logic [DW-1:0]  bus_rdata;
    logic [NCH-2:0] irq_out;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    dma_irq_unit #(.NCH(NCH), .SHARE_LO(3), .DW(DW)) i_dma_irq_unit (
        .clk(clk), .rst_n(rst_n), .evt_ht(evt_ht), .evt_tc(evt_tc), .evt_err(evt_err),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_out(irq_out)
    );

    function automatic logic [31:0] fld(int c, bit g, bit tc, bit ht, bit er);
        logic [31:0] v = {28'd0, er, ht, tc, g};
        return v << (4 * c);
    endfunction

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(logic [1:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic pulse(int c, int kind);
        @(negedge clk);
        if (kind == 0) evt_tc[c] = 1'b1;
        else if (kind == 1) evt_ht[c] = 1'b1;
        else evt_err[c] = 1'b1;
        @(negedge clk);
        evt_tc = '0; evt_ht = '0; evt_err = '0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check(irq_out == '0, "R1 irq", {26'd0, irq_out}, 32'd0);
        check(bus_rdata == '0, "R1 rdata", bus_rdata, 32'd0);
        bus_read(2'd0, d); check(d == 0, "R1 status", d, 32'd0);
        bus_read(2'd2, d); check(d == 0, "R1 enable", d, 32'd0);
    endtask

    task automatic t_set_and_status_write();
        logic [31:0] d;
        pulse(2, 0);
        bus_read(2'd0, d); check(d == fld(2,1,1,0,0), "R2 R3 tc ch2", d, fld(2,1,1,0,0));
        pulse(0, 2);
        bus_read(2'd0, d);
        check(d == (fld(2,1,1,0,0) | fld(0,1,0,0,1)), "R2 err ch0", d, fld(2,1,1,0,0) | fld(0,1,0,0,1));
        bus_write(2'd0, 32'hFFFF_FFFF);
        bus_write(2'd0, 32'h0000_0000);
        bus_read(2'd0, d);
        check(d == (fld(2,1,1,0,0) | fld(0,1,0,0,1)), "R4 status write", d, fld(2,1,1,0,0) | fld(0,1,0,0,1));
    endtask

    task automatic t_clear();
        logic [31:0] d;
        bus_write(2'd1, 32'h0);
        bus_read(2'd0, d);
        check(d == (fld(2,1,1,0,0) | fld(0,1,0,0,1)), "R5 zero clear", d, fld(2,1,1,0,0) | fld(0,1,0,0,1));
        bus_write(2'd1, fld(2,0,1,0,0));
        bus_read(2'd0, d); check(d == fld(0,1,0,0,1), "R5 clear tc ch2", d, fld(0,1,0,0,1));
        bus_read(2'd1, d); check(d == 0, "R7 clear reads zero", d, 32'd0);
        pulse(5, 0); pulse(5, 1); pulse(5, 2);
        bus_read(2'd0, d);
        check(d == (fld(0,1,0,0,1) | fld(5,1,1,1,1)), "R2 R3 ch5 all", d, fld(0,1,0,0,1) | fld(5,1,1,1,1));
        bus_write(2'd1, fld(5,1,0,0,0));
        bus_read(2'd0, d); check(d == fld(0,1,0,0,1), "R6 global clear", d, fld(0,1,0,0,1));
        bus_write(2'd1, 32'hFFFF_FFFF);
        bus_read(2'd0, d); check(d == 0, "R6 clear all", d, 32'd0);
    endtask

    task automatic t_collide();
        logic [31:0] d;
        pulse(1, 0);
        @(negedge clk);
        evt_tc[1] = 1'b1; bus_wr = 1'b1; bus_addr = 2'd1; bus_wdata = fld(1,0,1,0,0);
        @(negedge clk);
        evt_tc = '0; bus_wr = 1'b0;
        bus_read(2'd0, d); check(d == fld(1,1,1,0,0), "R8 own-bit collision", d, fld(1,1,1,0,0));
        @(negedge clk);
        evt_ht[1] = 1'b1; bus_wr = 1'b1; bus_addr = 2'd1; bus_wdata = fld(1,1,0,0,0);
        @(negedge clk);
        evt_ht = '0; bus_wr = 1'b0;
        bus_read(2'd0, d); check(d == fld(1,1,0,1,0), "R8 global collision", d, fld(1,1,0,1,0));
        bus_write(2'd1, 32'hFFFF_FFFF);
    endtask

    task automatic t_enable_irq();
        logic [31:0] d;
        bus_write(2'd2, 32'hFFFF_FFFF);
        bus_read(2'd2, d); check(d == 32'h0EEE_EEEE, "R9 enable readback", d, 32'h0EEE_EEEE);
        bus_write(2'd3, 32'hFFFF_FFFF);
        bus_read(2'd3, d); check(d == 0, "R9 unused address", d, 32'd0);
        bus_write(2'd2, 32'h0);
        pulse(0, 1);
        check(irq_out == '0, "R10 masked ht", {26'd0, irq_out}, 32'd0);
        bus_write(2'd2, fld(0,0,0,1,0));
        check(irq_out == 6'b000001, "R10 enabled ht", {26'd0, irq_out}, 32'd1);
        bus_write(2'd1, fld(0,0,0,1,0));
        check(irq_out == '0, "R10 cleared", {26'd0, irq_out}, 32'd0);
        bus_write(2'd2, 32'h0EEE_EEEE);
        for (int c = 3; c < NCH; c++) begin
            logic [5:0] exp;
            exp = (c <= 4) ? 6'b001000 : 6'(1 << (c - 1));
            pulse(c, 0);
            check(irq_out == exp, "R11 line map", {26'd0, irq_out}, {26'd0, exp});
            bus_write(2'd1, 32'hFFFF_FFFF);
        end
        pulse(1, 2);
        check(irq_out == 6'b000010, "R11 own line ch1", {26'd0, irq_out}, 32'd2);
    endtask

    task automatic t_rdata_hold();
        logic [31:0] d;
        bus_read(2'd0, d);
        pulse(6, 2);
        repeat (3) @(negedge clk);
        check(bus_rdata == d, "R12 hold", bus_rdata, d);
        bus_read(2'd0, d);
        check(d == (fld(1,1,0,0,1) | fld(6,1,0,0,1)), "R12 update", d, fld(1,1,0,0,1) | fld(6,1,0,0,1));
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; evt_ht = '0; evt_tc = '0; evt_err = '0;
        bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_set_and_status_write();
        t_clear();
        t_collide();
        t_enable_irq();
        t_rdata_hold();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule